// File: doc/BRIEF.md
# Transmitter Power-Mode Sequencer

This block steps a transmitter through four power levels: fully down, oscillator running, oscillator plus synthesizer running, and transmitting with the power amplifier on. It reads three kinds of input. A register command names a target level. A transmit enable pin marks the span of a transmission. A supply-fault flag can be gated by a detection-enable bit. From the current level it produces enable outputs for the oscillator, the synthesizer and the amplifier, and a select that puts the oscillator on its regulated supply.

Below transmit, the block moves one level per step toward the most recently commanded target. Each of those states must be held for a minimum number of reference clock cycles before the next step. Transmit is entered only from the synthesizer-running level, and only once the loop reports lock and the enable pin is high. Transmit is left at once, and where the block lands depends on the cause. A supply fault lands it at oscillator-running. A new register command also lands it at oscillator-running. The enable pin going low lands it at synthesizer-running.

Top module: `txpwr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `state_o` is 0 (down) and `osc_en`, `pll_en`, `pa_en` and `osc_supply_sel` are all low.
- R2: Outside transmit, a state is left only after it has been held for at least MIN_DWELL+1 cycles, unless a fault forces the move. When the target is pending and the move is allowed, the state is left after exactly MIN_DWELL+1 cycles.
- R3: `state_o` encodes down=0, oscillator=1, synthesizer=2, transmit=3. `cmd_op` uses the same codes to name a target. Outside transmit, an accepted `cmd_valid` latches the target, and the state then steps one level at a time toward it.
- R4: Transmit is entered only from state 2. It needs a latched target of 3, `pll_lock` high, `en_pin` high and the dwell of R2 completed.
- R5: In transmit with no enabled fault and no register command, `en_pin` low moves the state to 2 on the next cycle, and the target becomes 2.
- R6: In transmit with no enabled fault, `cmd_valid` with a `cmd_op` other than 3 moves the state to 1 on the next cycle, and that op becomes the target. A `cmd_op` of 3 in transmit has no effect.
- R7: In transmit, an enabled fault (`pf_detect_en` and `pf_flag` both high) moves the state to 1 on the next cycle. It takes precedence over R5 and R6.
- R8: While a fault is enabled, `pll_en` and `pa_en` are low in the same cycle. In state 2 the fault moves the state to 1 on the next cycle, and no step into state 2 or 3 is taken while the fault lasts.
- R9: `pf_flag` has no effect while `pf_detect_en` is low.
- R10: `osc_supply_sel` is high exactly when the state is 3 and `xsup_reg_en` is high.
- R11: `osc_en` is high in every state except 0. `pll_en` is high in states 2 and 3. `pa_en` is high only in state 3. Both `pll_en` and `pa_en` are still subject to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Register command strobe |
| cmd_op | input | 2 | Commanded target level (0..3) |
| en_pin | input | 1 | Transmit enable pin |
| pll_lock | input | 1 | Synthesizer lock indication |
| pf_detect_en | input | 1 | Supply-fault detection enable |
| pf_flag | input | 1 | Supply-fault flag |
| xsup_reg_en | input | 1 | Use regulated oscillator supply during transmit |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| pa_en | output | 1 | Power amplifier enable |
| osc_supply_sel | output | 1 | Oscillator supply select, 1 = regulated |
| state_o | output | 2 | Current level code |

## Verification
The bench builds the block with MIN_DWELL = 3 rather than the default 2. This makes each held interval four cycles long, so a dwell that is off by one cycle cannot match the expected count. With that value, random command bursts often land while a dwell is still in progress, and the bench also applies simultaneous fault, command and pin-low events in transmit. Together these exercise the pending-target stepping and the precedence among the three exit causes.

// File: rtl/txpwr_pkg.sv
// Shared types for the transmitter power-mode sequencer.
// Assumes level codes are ordered so that a higher code means more blocks powered.
package txpwr_pkg;
    typedef enum logic [1:0] {
        LVL_DOWN = 2'd0,
        LVL_OSC  = 2'd1,
        LVL_PLL  = 2'd2,
        LVL_TX   = 2'd3
    } pwr_lvl_t;
endpackage

// File: rtl/txpwr_dwell.sv
// Dwell timer: counts cycles since the last level change, saturating at MIN_DWELL.
// Assumes MIN_DWELL >= 1; done is high once the current level has been held MIN_DWELL+1 cycles.
module txpwr_dwell #(
    parameter int MIN_DWELL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CW = $clog2(MIN_DWELL + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_DWELL);

    logic [CW-1:0] cnt_q;

    // Purpose: restart on every level change, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag that the minimum hold has elapsed.
    always_comb begin
        done = (cnt_q == LIMIT);
    end
endmodule

// File: rtl/txpwr_fsm.sv
// Level sequencer: holds the current level and the latched target level.
// Below transmit it steps one level toward the target once the dwell is done;
// in transmit it exits at once on fault, register command or enable-pin low.
// Assumes fault is already qualified by the detection enable.
module txpwr_fsm
    import txpwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  pwr_lvl_t cmd_op,
    input  logic     en_pin,
    input  logic     pll_lock,
    input  logic     fault,
    input  logic     dwell_done,
    output pwr_lvl_t lvl,
    output logic     lvl_change
);
    pwr_lvl_t lvl_q, lvl_d;
    pwr_lvl_t tgt_q, tgt_d;

    // Purpose: compute the next level and next target from the current ones.
    always_comb begin
        lvl_d = lvl_q;
        tgt_d = tgt_q;
        if (cmd_valid && lvl_q != LVL_TX) begin
            tgt_d = cmd_op;
        end
        unique case (lvl_q)
            LVL_TX: begin
                if (fault) begin
                    lvl_d = LVL_OSC;
                    tgt_d = LVL_OSC;
                end else if (cmd_valid && cmd_op != LVL_TX) begin
                    lvl_d = LVL_OSC;
                    tgt_d = cmd_op;
                end else if (!en_pin) begin
                    lvl_d = LVL_PLL;
                    tgt_d = LVL_PLL;
                end
            end
            LVL_PLL: begin
                if (fault) begin
                    lvl_d = LVL_OSC;
                    tgt_d = LVL_OSC;
                end else if (dwell_done) begin
                    if (tgt_q == LVL_TX) begin
                        if (pll_lock && en_pin) begin
                            lvl_d = LVL_TX;
                        end
                    end else if (tgt_q != LVL_PLL) begin
                        lvl_d = LVL_OSC;
                    end
                end
            end
            LVL_OSC: begin
                if (dwell_done) begin
                    if (tgt_q == LVL_DOWN) begin
                        lvl_d = LVL_DOWN;
                    end else if (tgt_q != LVL_OSC && !fault) begin
                        lvl_d = LVL_PLL;
                    end
                end
            end
            default: begin
                if (dwell_done && tgt_q != LVL_DOWN) begin
                    lvl_d = LVL_OSC;
                end
            end
        endcase
    end

    // Purpose: register level and target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_DOWN;
            tgt_q <= LVL_DOWN;
        end else begin
            lvl_q <= lvl_d;
            tgt_q <= tgt_d;
        end
    end

    // Purpose: expose level and the change indication for the dwell timer.
    always_comb begin
        lvl        = lvl_q;
        lvl_change = (lvl_d != lvl_q);
    end
endmodule

// File: rtl/txpwr_drive.sv
// Output decode: turns the current level into block enables and the supply select.
// Assumes fault is already qualified; it gates the synthesizer and amplifier directly.
module txpwr_drive
    import txpwr_pkg::*;
(
    input  pwr_lvl_t lvl,
    input  logic     fault,
    input  logic     xsup_reg_en,
    output logic     osc_en,
    output logic     pll_en,
    output logic     pa_en,
    output logic     osc_supply_sel
);
    // Purpose: decode enables per level, with the fault gate on synthesizer and amplifier.
    always_comb begin
        osc_en         = (lvl != LVL_DOWN);
        pll_en         = (lvl == LVL_PLL || lvl == LVL_TX) && !fault;
        pa_en          = (lvl == LVL_TX) && !fault;
        osc_supply_sel = (lvl == LVL_TX) && xsup_reg_en;
    end
endmodule

// File: rtl/txpwr_seq.sv
// Top of the transmitter power-mode sequencer.
// Qualifies the fault input, then wires the level sequencer, the dwell timer and the output decode.
// Assumes all inputs are synchronous to clk.
module txpwr_seq
    import txpwr_pkg::*;
#(
    parameter int MIN_DWELL = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       en_pin,
    input  logic       pll_lock,
    input  logic       pf_detect_en,
    input  logic       pf_flag,
    input  logic       xsup_reg_en,
    output logic       osc_en,
    output logic       pll_en,
    output logic       pa_en,
    output logic       osc_supply_sel,
    output logic [1:0] state_o
);
    logic     fault;
    logic     lvl_change;
    logic     dwell_done;
    pwr_lvl_t lvl;

    // Purpose: a fault counts only while detection is enabled.
    always_comb begin
        fault = pf_detect_en && pf_flag;
    end

    txpwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (pwr_lvl_t'(cmd_op)),
        .en_pin     (en_pin),
        .pll_lock   (pll_lock),
        .fault      (fault),
        .dwell_done (dwell_done),
        .lvl        (lvl),
        .lvl_change (lvl_change)
    );

    txpwr_dwell #(.MIN_DWELL(MIN_DWELL)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (lvl_change),
        .done    (dwell_done)
    );

    txpwr_drive u_drive (
        .lvl            (lvl),
        .fault          (fault),
        .xsup_reg_en    (xsup_reg_en),
        .osc_en         (osc_en),
        .pll_en         (pll_en),
        .pa_en          (pa_en),
        .osc_supply_sel (osc_supply_sel)
    );

    // Purpose: publish the level code.
    always_comb begin
        state_o = lvl;
    end
endmodule

// File: rtl/txpwr_seq_chk.sv
// Property checker for txpwr_seq, attached with bind.
// Tracks how long the level has been held, using its own counter, to check the dwell rule.
module txpwr_seq_chk #(
    parameter int MIN_DWELL = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       en_pin,
    input logic       pll_lock,
    input logic       pf_detect_en,
    input logic       pf_flag,
    input logic       xsup_reg_en,
    input logic       osc_en,
    input logic       pll_en,
    input logic       pa_en,
    input logic       osc_supply_sel,
    input logic [1:0] state_o
);
    logic [1:0]  prev_st;
    logic [31:0] hold;
    logic        prev_fault;
    logic        flt;

    always_comb flt = pf_detect_en && pf_flag;

    // Purpose: count consecutive samples of the same level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_st    <= 2'd0;
            hold       <= 32'd0;
            prev_fault <= 1'b0;
        end else begin
            prev_st    <= state_o;
            prev_fault <= flt;
            if (state_o != prev_st) hold <= 32'd1;
            else if (hold < 32'(MIN_DWELL + 1)) hold <= hold + 32'd1;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (state_o == 2'd0 && !osc_en && !pll_en && !pa_en && !osc_supply_sel));

    p_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != prev_st && prev_st != 2'd3 && state_o != 2'd3 && !prev_fault)
        |-> hold >= 32'(MIN_DWELL + 1));

    p_tx_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd3) |=> (state_o != 2'd3 || ($past(state_o) == 2'd2 && $past(pll_lock) && $past(en_pin))));

    p_pin_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !en_pin && !flt && !(cmd_valid && cmd_op != 2'd3)) |=> state_o == 2'd2);

    p_reg_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && cmd_valid && cmd_op != 2'd3 && !flt) |=> state_o == 2'd1);

    p_fault_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && flt) |=> state_o == 2'd1);

    p_fault_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt |-> (!pll_en && !pa_en));

    p_supply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        osc_supply_sel |-> (state_o == 2'd3 && xsup_reg_en));

    p_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> (pll_en && osc_en));
endmodule

bind txpwr_seq txpwr_seq_chk #(.MIN_DWELL(MIN_DWELL)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .en_pin         (en_pin),
    .pll_lock       (pll_lock),
    .pf_detect_en   (pf_detect_en),
    .pf_flag        (pf_flag),
    .xsup_reg_en    (xsup_reg_en),
    .osc_en         (osc_en),
    .pll_en         (pll_en),
    .pa_en          (pa_en),
    .osc_supply_sel (osc_supply_sel),
    .state_o        (state_o)
);

// File: tb/txpwr_seq_test.sv
// Bench for txpwr_seq: directed corner cases and seeded random stimulus,
// compared every cycle against a level model built from the requirements.
module txpwr_seq_test;
    localparam int DW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       en_pin = 1'b0;
    logic       pll_lock = 1'b0;
    logic       pf_detect_en = 1'b0;
    logic       pf_flag = 1'b0;
    logic       xsup_reg_en = 1'b0;
    logic       osc_en, pll_en, pa_en, osc_supply_sel;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [1:0] m_st = 2'd0;
    logic [1:0] m_tgt = 2'd0;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    txpwr_seq #(.MIN_DWELL(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .en_pin(en_pin), .pll_lock(pll_lock), .pf_detect_en(pf_detect_en),
        .pf_flag(pf_flag), .xsup_reg_en(xsup_reg_en), .osc_en(osc_en),
        .pll_en(pll_en), .pa_en(pa_en), .osc_supply_sel(osc_supply_sel),
        .state_o(state_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit fault_now();
        return pf_detect_en && pf_flag;
    endfunction

    // Model next level per R2..R9
    task automatic model_step();
        logic [1:0] n_st;
        logic [1:0] n_tgt;
        bit ok;
        bit f;
        if (!rst_n) begin
            m_st = 2'd0; m_tgt = 2'd0; m_cnt = 0;
            return;
        end
        f = fault_now();
        ok = (m_cnt >= DW);
        n_st = m_st; n_tgt = m_tgt;
        if (cmd_valid && m_st != 2'd3) n_tgt = cmd_op;
        case (m_st)
            2'd3: begin
                if (f) begin n_st = 2'd1; n_tgt = 2'd1; end
                else if (cmd_valid && cmd_op != 2'd3) begin n_st = 2'd1; n_tgt = cmd_op; end
                else if (!en_pin) begin n_st = 2'd2; n_tgt = 2'd2; end
            end
            2'd2: begin
                if (f) begin n_st = 2'd1; n_tgt = 2'd1; end
                else if (ok) begin
                    if (m_tgt == 2'd3) begin if (pll_lock && en_pin) n_st = 2'd3; end
                    else if (m_tgt != 2'd2) n_st = 2'd1;
                end
            end
            2'd1: begin
                if (ok) begin
                    if (m_tgt == 2'd0) n_st = 2'd0;
                    else if (m_tgt != 2'd1 && !f) n_st = 2'd2;
                end
            end
            default: if (ok && m_tgt != 2'd0) n_st = 2'd1;
        endcase
        if (n_st != m_st) m_cnt = 0;
        else if (m_cnt < DW) m_cnt++;
        m_st = n_st; m_tgt = n_tgt;
    endtask

    task automatic compare();
        bit f;
        f = fault_now();
        chk(state_o == m_st, "R3 state", state_o, m_st);
        chk(osc_en == (m_st != 2'd0), "R11 osc_en", osc_en, m_st != 2'd0);
        chk(pll_en == (m_st >= 2'd2 && !f), "R8 pll_en", pll_en, m_st >= 2'd2 && !f);
        chk(pa_en == (m_st == 2'd3 && !f), "R11 pa_en", pa_en, m_st == 2'd3 && !f);
        chk(osc_supply_sel == (m_st == 2'd3 && xsup_reg_en), "R10 supply",
            osc_supply_sel, m_st == 2'd3 && xsup_reg_en);
    endtask

    // One clock: model update at the edge, compare at the following falling edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic pulse_cmd(input logic [1:0] op);
        cmd_valid = 1'b1; cmd_op = op;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic go_tx();
        pulse_cmd(2'd3);
        for (int i = 0; i < 60 && state_o != 2'd3; i++) tick();
        chk(state_o == 2'd3, "R4 reach transmit", state_o, 3);
    endtask

    task automatic hold_len(input logic [1:0] lvl, input logic [1:0] next, input string req);
        int n;
        n = 0;
        for (int i = 0; i < 60 && state_o != lvl; i++) tick();
        while (state_o == lvl && n < 60) begin tick(); n++; end
        chk(n == DW + 1, req, n, DW + 1);
        chk(state_o == next, req, state_o, next);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) tick();
        // R1: reset state
        chk(state_o == 2'd0 && !osc_en && !pll_en && !pa_en && !osc_supply_sel,
            "R1 reset outputs", {osc_en, pll_en, pa_en, osc_supply_sel}, 0);
        rst_n = 1'b1;
        tick();
        chk(state_o == 2'd0 && !osc_en, "R1 after release", state_o, 0);

        // R2/R3/R4: climb from down to transmit with exact holds
        en_pin = 1'b1; pll_lock = 1'b1;
        pulse_cmd(2'd3);
        hold_len(2'd1, 2'd2, "R2 oscillator hold");
        hold_len(2'd2, 2'd3, "R4 synthesizer hold then transmit");

        // R10: supply select follows transmit
        xsup_reg_en = 1'b1; tick();
        chk(osc_supply_sel == 1'b1, "R10 regulated in transmit", osc_supply_sel, 1);
        // R6: transmit command in transmit has no effect
        pulse_cmd(2'd3);
        chk(state_o == 2'd3, "R6 tx op ignored", state_o, 3);

        // R5: enable pin low
        en_pin = 1'b0; tick(); en_pin = 1'b1;
        chk(state_o == 2'd2, "R5 pin exit", state_o, 2);
        chk(osc_supply_sel == 1'b0, "R10 unregulated after exit", osc_supply_sel, 0);
        for (int i = 0; i < 8; i++) tick();
        chk(state_o == 2'd2, "R5 target now synthesizer", state_o, 2);

        // R6: register write exit
        go_tx();
        pulse_cmd(2'd2);
        chk(state_o == 2'd1, "R6 register exit", state_o, 1);
        hold_len(2'd1, 2'd2, "R6 target follows op");

        // R9: fault ignored when detection off
        go_tx();
        pf_flag = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        chk(state_o == 2'd3 && pa_en, "R9 fault ignored", state_o, 3);

        // R7/R8: enabled fault with command and pin low at once
        pf_detect_en = 1'b1;
        #1;
        chk(!pa_en && !pll_en, "R8 gate same cycle", {pll_en, pa_en}, 0);
        cmd_valid = 1'b1; cmd_op = 2'd0; en_pin = 1'b0;
        tick();
        cmd_valid = 1'b0; en_pin = 1'b1;
        chk(state_o == 2'd1, "R7 fault priority", state_o, 1);
        pulse_cmd(2'd3);
        for (int i = 0; i < 12; i++) tick();
        chk(state_o == 2'd1, "R8 no climb during fault", state_o, 1);
        pf_flag = 1'b0; pf_detect_en = 1'b0;

        // Random phase
        for (int i = 0; i < 5000; i++) begin
            cmd_valid = (($urandom % 7) == 0);
            cmd_op = 2'($urandom);
            if (($urandom % 30) == 0) en_pin = ~en_pin;
            pll_lock = (($urandom % 8) != 0);
            pf_flag = (($urandom % 40) == 0);
            if (($urandom % 300) == 0) pf_detect_en = ~pf_detect_en;
            if (($urandom % 100) == 0) xsup_reg_en = ~xsup_reg_en;
            if (($urandom % 1500) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule